// File: doc/BRIEF.md
# Fetch Group Extractor

This block sits between the instruction cache and the decode stage of a pipelined processor. Each cycle in which the caller raises a request with a fetch PC and the matching cache line, it cuts a group of consecutive instruction words out of the line. Each word carries its own PC, a predicted successor PC and a program-order sequence number. One cycle later it presents the whole group to decode, together with the address the next fetch should use.

The block never holds predictor state or does full decoding. It exposes the candidate instruction words so that an external pre-decoder can return a control-flow flag for each slot. For every in-line control slot it raises a request to an external branch predictor, which answers in the same cycle with a taken flag and a target. A group ends at the first of three limits: the fetch width, the end of the cache line, or the first branch predicted taken, which is itself kept in the group. When the request carries a fault, nothing is emitted and the PC and counters stay where they were.

Top module: `fge_top`

## Requirements
- R1: `line_addr` equals `fetch_pc` with its low log2(LINE_BYTES) bits (6 by default) cleared; the starting word is `fetch_pc` bits [5:2].
- R2: The group length is the smallest of FETCH_W, the number of words from the start word to the line end, and one plus the index of the first slot predicted taken. `out_count` is 1 to FETCH_W when `out_valid` is high. `out_stop` encodes why the group ended: 2 for taken, otherwise 1 when the last slot is the final word of the line, otherwise 0 for width.
- R3: Slot i has PC `fetch_pc + 4*i` and instruction word {byte o+3, o+2, o+1, o}, where o = (fetch_pc mod 64) + 4*i and byte k is `line_data[8k+7:8k]` (little-endian).
- R4: A non-control slot, and a control slot predicted not taken, gets next PC = its PC + 4 and a clear taken bit in `out_taken`.
- R5: A control slot whose predictor answer is taken gets next PC = `bp_target` for that slot and a set taken bit, and it is the last slot of the group.
- R6: Sequence numbers start at 0 after reset, rise by one per emitted instruction in slot order, and continue across groups.
- R7: After a group, `next_pc` equals the next PC of its last slot and `next_pc_inc` equals that value plus 4.
- R8: A request with `line_fault` high emits no group. It leaves `next_pc`, `next_pc_inc`, the sequence numbering and `taken_total` unchanged.
- R9: `taken_total` rises by one for each group that ends on a taken prediction and is otherwise unchanged.
- R10: `out_valid` is high for exactly the cycle after each accepted request and low after any cycle without one.
- R11: After reset `out_valid` is 0, `out_count` is 0, `next_pc` is RESET_PC (0), `next_pc_inc` is 4 and `taken_total` is 0.
- R12: `bp_req_valid[i]` is high only when a request is present, slot i lies inside the line, and `is_ctrl[i]` is set; `bp_req_pc` slot i carries that slot's PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Fetch request this cycle |
| line_fault | input | 1 | Line could not be supplied; request produces nothing |
| fetch_pc | input | PC_W | Fetch PC |
| line_data | input | 8*LINE_BYTES | Full cache line, byte k at bits [8k+7:8k] |
| is_ctrl | input | FETCH_W | Pre-decode flag per candidate slot |
| bp_taken | input | FETCH_W | Predictor taken answer per slot |
| bp_target | input | FETCH_W*PC_W | Predictor target per slot |
| line_addr | output | PC_W | Line-aligned request address |
| cand_inst | output | FETCH_W*8*INST_BYTES | Candidate instruction words for pre-decode |
| bp_req_valid | output | FETCH_W | Predictor lookup request per slot |
| bp_req_pc | output | FETCH_W*PC_W | PC of each candidate slot |
| out_valid | output | 1 | Group strobe |
| out_count | output | $clog2(FETCH_W+1) | Number of valid slots |
| out_stop | output | 2 | Reason the group ended |
| out_inst | output | FETCH_W*8*INST_BYTES | Slot instruction words |
| out_pc | output | FETCH_W*PC_W | Slot PCs |
| out_npc | output | FETCH_W*PC_W | Slot predicted next PCs |
| out_taken | output | FETCH_W | Slot predicted-taken bits |
| out_seq | output | FETCH_W*SEQ_W | Slot sequence numbers |
| next_pc | output | PC_W | Next fetch PC |
| next_pc_inc | output | PC_W | Next fetch PC plus instruction size |
| taken_total | output | CNT_W | Count of groups ended by a taken branch |

## Verification
The limits collide when a taken branch sits in the final word of the line or in the last slot of the width, and when the width runs out exactly at the line end. Sweeping every start word against every pre-decode mask and every predictor taken mask places taken branches at each slot for each distance to the line end, so all of these coincidences occur. The bench judges each group by its count, its stop code and the successor PC of the last slot, all computed from the stated precedence of taken over line end over width.

// File: rtl/fge_pkg.sv
// Package: shared encodings for the fetch group extractor.
// Assumes: nothing beyond standard SystemVerilog.
package fge_pkg;

    // Reason a fetch group stopped; precedence taken > line end > width.
    typedef enum logic [1:0] {
        STOP_WIDTH = 2'd0,
        STOP_LINE  = 2'd1,
        STOP_TAKEN = 2'd2
    } fge_stop_e;

    localparam int FGE_BYTE_BITS = 8;

endpackage

// File: rtl/fge_slot_window.sv
// Module: fge_slot_window
// Slices FETCH_W consecutive instruction words out of a cache line,
// starting at the word addressed by the fetch PC, and gives each slot its PC
// and an in-line flag.
// Assumes: LINE_BYTES and INST_BYTES are powers of two, LINE_BYTES >= INST_BYTES,
// and line bytes are packed little-endian (byte k at bits [8k+7:8k]).
module fge_slot_window
    import fge_pkg::*;
#(
    parameter int PC_W       = 32,
    parameter int LINE_BYTES = 64,
    parameter int INST_BYTES = 4,
    parameter int FETCH_W    = 4
) (
    input  logic [PC_W-1:0]                          fetch_pc,
    input  logic [LINE_BYTES*FGE_BYTE_BITS-1:0]      line_data,
    output logic [$clog2(LINE_BYTES/INST_BYTES)-1:0] start_word,
    output logic [FETCH_W*PC_W-1:0]                  slot_pc,
    output logic [FETCH_W*INST_BYTES*FGE_BYTE_BITS-1:0] slot_inst,
    output logic [FETCH_W-1:0]                       slot_in_line
);
    localparam int INST_BITS = INST_BYTES * FGE_BYTE_BITS;
    localparam int WORDS     = LINE_BYTES / INST_BYTES;
    localparam int WIDX_W    = $clog2(WORDS);
    localparam int OFF_W     = $clog2(LINE_BYTES);
    localparam int IOFF_W    = $clog2(INST_BYTES);

    // Word index of the first slot inside the line.
    assign start_word = fetch_pc[OFF_W-1:IOFF_W];

    for (genvar i = 0; i < FETCH_W; i++) begin : g_slot
        logic [WIDX_W:0] widx;

        // Absolute word index of slot i, one bit wider to detect line overrun.
        assign widx = {1'b0, start_word} + (WIDX_W+1)'(i);

        // Slot lies inside the line when its word index is below the word count.
        assign slot_in_line[i] = (widx < (WIDX_W+1)'(WORDS));

        // Little-endian word at the slot offset (wrapped index is masked by in-line flag).
        assign slot_inst[i*INST_BITS +: INST_BITS] =
            line_data[widx[WIDX_W-1:0]*INST_BITS +: INST_BITS];

        // Sequential PC of slot i.
        assign slot_pc[i*PC_W +: PC_W] = fetch_pc + PC_W'(i * INST_BYTES);
    end

endmodule

// File: rtl/fge_group_limit.sv
// Module: fge_group_limit
// Decides per-slot successor PCs and taken bits from pre-decode flags and the
// predictor answers, then finds where the group ends and why.
// Assumes: slot PCs are sequential; predictor answers are valid in the same
// cycle for every slot whose request is raised.
module fge_group_limit
    import fge_pkg::*;
#(
    parameter int PC_W       = 32,
    parameter int LINE_BYTES = 64,
    parameter int INST_BYTES = 4,
    parameter int FETCH_W    = 4
) (
    input  logic [FETCH_W*PC_W-1:0]                  slot_pc,
    input  logic [FETCH_W-1:0]                       slot_in_line,
    input  logic [$clog2(LINE_BYTES/INST_BYTES)-1:0] start_word,
    input  logic [FETCH_W-1:0]                       is_ctrl,
    input  logic [FETCH_W-1:0]                       bp_taken,
    input  logic [FETCH_W*PC_W-1:0]                  bp_target,
    output logic [FETCH_W*PC_W-1:0]                  slot_npc,
    output logic [FETCH_W-1:0]                       slot_tk,
    output logic [$clog2(FETCH_W+1)-1:0]             grp_cnt,
    output fge_stop_e                                grp_stop,
    output logic [PC_W-1:0]                          last_npc,
    output logic                                     last_tk
);
    localparam int WORDS  = LINE_BYTES / INST_BYTES;
    localparam int WIDX_W = $clog2(WORDS);
    localparam int GCNT_W = $clog2(FETCH_W+1);
    localparam int SUM_W  = WIDX_W + GCNT_W + 1;

    for (genvar i = 0; i < FETCH_W; i++) begin : g_npc
        // Taken only for control slots the predictor marks taken.
        assign slot_tk[i] = is_ctrl[i] & bp_taken[i];

        // Successor PC: predictor target when taken, else fall-through.
        assign slot_npc[i*PC_W +: PC_W] = slot_tk[i] ? bp_target[i*PC_W +: PC_W]
                                        : slot_pc[i*PC_W +: PC_W] + PC_W'(INST_BYTES);
    end

    // Walk the slots in order and stop at the first limit reached.
    always_comb begin
        logic done;
        done     = 1'b0;
        grp_cnt  = '0;
        grp_stop = STOP_WIDTH;
        last_npc = slot_pc[PC_W-1:0];
        last_tk  = 1'b0;
        for (int i = 0; i < FETCH_W; i++) begin
            if (!done) begin
                if (!slot_in_line[i]) begin
                    done     = 1'b1;
                    grp_stop = STOP_LINE;
                end else begin
                    grp_cnt  = grp_cnt + GCNT_W'(1);
                    last_npc = slot_npc[i*PC_W +: PC_W];
                    if (slot_tk[i]) begin
                        done     = 1'b1;
                        last_tk  = 1'b1;
                        grp_stop = STOP_TAKEN;
                    end
                end
            end
        end
        if (!done && (SUM_W'(start_word) + SUM_W'(FETCH_W) == SUM_W'(WORDS))) begin
            grp_stop = STOP_LINE;
        end
    end

endmodule

// File: rtl/fge_seq_track.sv
// Module: fge_seq_track
// Holds the running sequence base and the count of taken-ended groups.
// Assumes: fire is high only for accepted, fault-free requests.
module fge_seq_track #(
    parameter int FETCH_W = 4,
    parameter int SEQ_W   = 32,
    parameter int CNT_W   = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         fire,
    input  logic [$clog2(FETCH_W+1)-1:0] grp_cnt,
    input  logic                         last_tk,
    output logic [SEQ_W-1:0]             seq_base,
    output logic [CNT_W-1:0]             taken_total
);
    // Advance the sequence base by the group size on each accepted group.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_base <= '0;
        end else if (fire) begin
            seq_base <= seq_base + SEQ_W'(grp_cnt);
        end
    end

    // Count groups that ended on a taken prediction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            taken_total <= '0;
        end else if (fire && last_tk) begin
            taken_total <= taken_total + CNT_W'(1);
        end
    end

endmodule

// File: rtl/fge_top.sv
// Module: fge_top
// Fetch group extractor: turns a fetch PC and its cache line into a registered
// group of up to FETCH_W instructions with PCs, predicted successors and
// sequence numbers, and updates the next fetch PC.
// Assumes: pre-decode flags and predictor answers arrive combinationally in
// the request cycle; a faulting request is dropped without side effects.
module fge_top
    import fge_pkg::*;
#(
    parameter int              PC_W       = 32,
    parameter int              LINE_BYTES = 64,
    parameter int              INST_BYTES = 4,
    parameter int              FETCH_W    = 4,
    parameter int              SEQ_W      = 32,
    parameter int              CNT_W      = 16,
    parameter logic [PC_W-1:0] RESET_PC   = '0
) (
    input  logic                                     clk,
    input  logic                                     rst_n,
    input  logic                                     req_valid,
    input  logic                                     line_fault,
    input  logic [PC_W-1:0]                          fetch_pc,
    input  logic [LINE_BYTES*8-1:0]                  line_data,
    input  logic [FETCH_W-1:0]                       is_ctrl,
    input  logic [FETCH_W-1:0]                       bp_taken,
    input  logic [FETCH_W*PC_W-1:0]                  bp_target,
    output logic [PC_W-1:0]                          line_addr,
    output logic [FETCH_W*INST_BYTES*8-1:0]          cand_inst,
    output logic [FETCH_W-1:0]                       bp_req_valid,
    output logic [FETCH_W*PC_W-1:0]                  bp_req_pc,
    output logic                                     out_valid,
    output logic [$clog2(FETCH_W+1)-1:0]             out_count,
    output logic [1:0]                               out_stop,
    output logic [FETCH_W*INST_BYTES*8-1:0]          out_inst,
    output logic [FETCH_W*PC_W-1:0]                  out_pc,
    output logic [FETCH_W*PC_W-1:0]                  out_npc,
    output logic [FETCH_W-1:0]                       out_taken,
    output logic [FETCH_W*SEQ_W-1:0]                 out_seq,
    output logic [PC_W-1:0]                          next_pc,
    output logic [PC_W-1:0]                          next_pc_inc,
    output logic [CNT_W-1:0]                         taken_total
);
    localparam int INST_BITS = INST_BYTES * 8;
    localparam int WORDS     = LINE_BYTES / INST_BYTES;
    localparam int WIDX_W    = $clog2(WORDS);
    localparam int OFF_W     = $clog2(LINE_BYTES);
    localparam int GCNT_W    = $clog2(FETCH_W+1);

    logic [WIDX_W-1:0]          start_word;
    logic [FETCH_W*PC_W-1:0]    slot_pc;
    logic [FETCH_W*INST_BITS-1:0] slot_inst;
    logic [FETCH_W-1:0]         slot_in_line;
    logic [FETCH_W*PC_W-1:0]    slot_npc;
    logic [FETCH_W-1:0]         slot_tk;
    logic [GCNT_W-1:0]          grp_cnt;
    fge_stop_e                  grp_stop;
    logic [PC_W-1:0]            last_npc;
    logic                       last_tk;
    logic [SEQ_W-1:0]           seq_base;
    logic [FETCH_W-1:0]         slot_keep;
    logic                       fire;

    // Line-aligned address handed to the cache.
    assign line_addr = {fetch_pc[PC_W-1:OFF_W], OFF_W'(0)};

    // A request without a fault produces a group.
    assign fire = req_valid & ~line_fault;

    fge_slot_window #(
        .PC_W(PC_W), .LINE_BYTES(LINE_BYTES), .INST_BYTES(INST_BYTES), .FETCH_W(FETCH_W)
    ) u_window (
        .fetch_pc     (fetch_pc),
        .line_data    (line_data),
        .start_word   (start_word),
        .slot_pc      (slot_pc),
        .slot_inst    (slot_inst),
        .slot_in_line (slot_in_line)
    );

    fge_group_limit #(
        .PC_W(PC_W), .LINE_BYTES(LINE_BYTES), .INST_BYTES(INST_BYTES), .FETCH_W(FETCH_W)
    ) u_limit (
        .slot_pc      (slot_pc),
        .slot_in_line (slot_in_line),
        .start_word   (start_word),
        .is_ctrl      (is_ctrl),
        .bp_taken     (bp_taken),
        .bp_target    (bp_target),
        .slot_npc     (slot_npc),
        .slot_tk      (slot_tk),
        .grp_cnt      (grp_cnt),
        .grp_stop     (grp_stop),
        .last_npc     (last_npc),
        .last_tk      (last_tk)
    );

    fge_seq_track #(
        .FETCH_W(FETCH_W), .SEQ_W(SEQ_W), .CNT_W(CNT_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .fire        (fire),
        .grp_cnt     (grp_cnt),
        .last_tk     (last_tk),
        .seq_base    (seq_base),
        .taken_total (taken_total)
    );

    // Candidate words and predictor lookups, raised only for in-line control slots.
    assign cand_inst = slot_inst;
    assign bp_req_pc = slot_pc;
    assign bp_req_valid = {FETCH_W{req_valid}} & slot_in_line & is_ctrl;

    // Slots kept in the group are those below the group count.
    for (genvar i = 0; i < FETCH_W; i++) begin : g_keep
        assign slot_keep[i] = (GCNT_W'(i) < grp_cnt);
    end

    // Register the group and its bookkeeping toward decode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_count   <= '0;
            out_stop    <= STOP_WIDTH;
            out_inst    <= '0;
            out_pc      <= '0;
            out_npc     <= '0;
            out_taken   <= '0;
            out_seq     <= '0;
        end else if (fire) begin
            out_valid   <= 1'b1;
            out_count   <= grp_cnt;
            out_stop    <= grp_stop;
            out_inst    <= slot_inst;
            out_pc      <= slot_pc;
            out_npc     <= slot_npc;
            out_taken   <= slot_tk & slot_keep;
            for (int i = 0; i < FETCH_W; i++) begin
                out_seq[i*SEQ_W +: SEQ_W] <= seq_base + SEQ_W'(i);
            end
        end else begin
            out_valid   <= 1'b0;
            out_count   <= '0;
        end
    end

    // Update the next fetch PC pair only on fault-free groups.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            next_pc     <= RESET_PC;
            next_pc_inc <= RESET_PC + PC_W'(INST_BYTES);
        end else if (fire) begin
            next_pc     <= last_npc;
            next_pc_inc <= last_npc + PC_W'(INST_BYTES);
        end
    end

endmodule

// File: rtl/fge_chk.sv
// Module: fge_chk
// Checker for fge_top, attached with bind; watches ports only.
// Assumes: same parameters as the bound instance.
module fge_chk #(
    parameter int PC_W       = 32,
    parameter int INST_BYTES = 4,
    parameter int FETCH_W    = 4,
    parameter int SEQ_W      = 32,
    parameter int CNT_W      = 16
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         req_valid,
    input logic                         line_fault,
    input logic [FETCH_W-1:0]           bp_req_valid,
    input logic                         out_valid,
    input logic [$clog2(FETCH_W+1)-1:0] out_count,
    input logic [1:0]                   out_stop,
    input logic [FETCH_W*PC_W-1:0]      out_npc,
    input logic [FETCH_W-1:0]           out_taken,
    input logic [FETCH_W*SEQ_W-1:0]     out_seq,
    input logic [PC_W-1:0]              next_pc,
    input logic [CNT_W-1:0]             taken_total
);
    logic [PC_W-1:0] tail_npc;
    logic            tail_tk;
    logic            seq_ok;

    // Successor PC and taken bit of the last valid slot, plus seq contiguity.
    always_comb begin
        tail_npc = '0;
        tail_tk  = 1'b0;
        seq_ok   = 1'b1;
        for (int i = 0; i < FETCH_W; i++) begin
            if (int'(out_count) == i + 1) begin
                tail_npc = out_npc[i*PC_W +: PC_W];
                tail_tk  = out_taken[i];
            end
            if (i > 0 && i < int'(out_count)) begin
                if (out_seq[i*SEQ_W +: SEQ_W] != out_seq[(i-1)*SEQ_W +: SEQ_W] + SEQ_W'(1))
                    seq_ok = 1'b0;
            end
        end
    end

    assert_count_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_count != 0) && (int'(out_count) <= FETCH_W));

    assert_taken_is_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_stop == 2'd2) |-> tail_tk);

    assert_seq_contig_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> seq_ok);

    assert_next_from_tail_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> next_pc == tail_npc);

    assert_fault_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && line_fault) |=> (!out_valid && $stable(next_pc) && $stable(taken_total)));

    assert_taken_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> taken_total == $past(taken_total) + CNT_W'(tail_tk));

    assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !out_valid);

    assert_bpreq_gated_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (bp_req_valid != '0) |-> req_valid);

endmodule

bind fge_top fge_chk #(
    .PC_W(PC_W), .INST_BYTES(INST_BYTES), .FETCH_W(FETCH_W), .SEQ_W(SEQ_W), .CNT_W(CNT_W)
) u_fge_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .line_fault   (line_fault),
    .bp_req_valid (bp_req_valid),
    .out_valid    (out_valid),
    .out_count    (out_count),
    .out_stop     (out_stop),
    .out_npc      (out_npc),
    .out_taken    (out_taken),
    .out_seq      (out_seq),
    .next_pc      (next_pc),
    .taken_total  (taken_total)
);

// File: tb/fge_top_tb.sv
module fge_top_tb;
    localparam int W = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          line_fault = 1'b0;
    logic [31:0]   fetch_pc = '0;
    logic [511:0]  line_data = '0;
    logic [W-1:0]  is_ctrl = '0;
    logic [W-1:0]  bp_taken = '0;
    logic [W*32-1:0] bp_target = '0;
    logic [31:0]   line_addr;
    logic [W*32-1:0] cand_inst;
    logic [W-1:0]  bp_req_valid;
    logic [W*32-1:0] bp_req_pc;
    logic          out_valid;
    logic [2:0]    out_count;
    logic [1:0]    out_stop;
    logic [W*32-1:0] out_inst;
    logic [W*32-1:0] out_pc;
    logic [W*32-1:0] out_npc;
    logic [W-1:0]  out_taken;
    logic [W*32-1:0] out_seq;
    logic [31:0]   next_pc;
    logic [31:0]   next_pc_inc;
    logic [15:0]   taken_total;

    int total = 0;
    int bad = 0;
    logic [31:0] seq_exp = 0;
    logic [15:0] tk_exp = 0;
    logic [31:0] npc_exp = 0;

    fge_top u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .line_fault(line_fault),
        .fetch_pc(fetch_pc), .line_data(line_data), .is_ctrl(is_ctrl),
        .bp_taken(bp_taken), .bp_target(bp_target), .line_addr(line_addr),
        .cand_inst(cand_inst), .bp_req_valid(bp_req_valid), .bp_req_pc(bp_req_pc),
        .out_valid(out_valid), .out_count(out_count), .out_stop(out_stop),
        .out_inst(out_inst), .out_pc(out_pc), .out_npc(out_npc),
        .out_taken(out_taken), .out_seq(out_seq), .next_pc(next_pc),
        .next_pc_inc(next_pc_inc), .taken_total(taken_total)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] line_byte(int k, int g);
        return 8'((k * 37 + g * 11 + 5) & 255);
    endfunction

    function automatic logic [31:0] tgt_of(logic [31:0] pc, int i);
        return pc + 32'h1000 * 32'(i + 1) + 32'h40;
    endfunction

    // One fault-free group: drive at negedge, check comb, check registered at next negedge.
    task automatic run_group(input int off, input int cm, input int tm, input int g);
        logic [31:0] pc;
        int cnt;
        int stop;
        bit last_t;
        logic [31:0] e_pc [W];
        logic [31:0] e_npc [W];
        logic [31:0] e_inst [W];
        bit e_tk [W];
        bit comb_ok;
        bit slot_ok;
        pc = 32'h0004_0000 + 32'((g & 255) << 6) + 32'(off * 4);
        fetch_pc = pc;
        for (int k = 0; k < 64; k++) line_data[k*8 +: 8] = line_byte(k, g);
        is_ctrl = W'(cm);
        bp_taken = W'(tm);
        for (int i = 0; i < W; i++) bp_target[i*32 +: 32] = tgt_of(pc + 32'(4 * i), i);
        req_valid = 1'b1;
        line_fault = 1'b0;
        // Expected group from the requirements.
        cnt = 0; stop = 0; last_t = 0;
        for (int i = 0; i < W; i++) begin
            int o;
            o = off * 4 + 4 * i;
            e_pc[i] = pc + 32'(4 * i);
            e_inst[i] = (o < 64) ? {line_byte(o + 3, g), line_byte(o + 2, g),
                                    line_byte(o + 1, g), line_byte(o, g)} : 32'h0;
            e_tk[i] = cm[i] && tm[i];
            e_npc[i] = e_tk[i] ? tgt_of(e_pc[i], i) : e_pc[i] + 32'd4;
        end
        for (int i = 0; i < W; i++) begin
            if (off + i >= 16) break;
            cnt++;
            if (e_tk[i]) begin last_t = 1; break; end
        end
        if (last_t) stop = 2; else if (off + cnt == 16) stop = 1; else stop = 0;
        #1;
        check(line_addr == {pc[31:6], 6'b0}, "R1 line_addr", 64'(line_addr), 64'({pc[31:6], 6'b0}));
        comb_ok = 1;
        for (int i = 0; i < W; i++) begin
            bit ev;
            ev = (off + i < 16) && cm[i];
            if (bp_req_valid[i] != ev) comb_ok = 0;
            if (ev && bp_req_pc[i*32 +: 32] != e_pc[i]) comb_ok = 0;
        end
        check(comb_ok, "R12 bp_req", 64'({bp_req_valid}), 64'(cm));
        @(negedge clk);
        check(out_valid == 1'b1, "R10 out_valid", 64'(out_valid), 64'd1);
        check(int'(out_count) == cnt, "R2 out_count", 64'(out_count), 64'(cnt));
        check(int'(out_stop) == stop, "R2 out_stop", 64'(out_stop), 64'(stop));
        for (int i = 0; i < cnt; i++) begin
            check(out_pc[i*32 +: 32] == e_pc[i], "R3 slot pc", 64'(out_pc[i*32 +: 32]), 64'(e_pc[i]));
            check(out_inst[i*32 +: 32] == e_inst[i], "R3 slot inst", 64'(out_inst[i*32 +: 32]), 64'(e_inst[i]));
            slot_ok = (out_npc[i*32 +: 32] == e_npc[i]) && (out_taken[i] == e_tk[i]);
            if (e_tk[i]) check(slot_ok, "R5 taken slot", 64'(out_npc[i*32 +: 32]), 64'(e_npc[i]));
            else         check(slot_ok, "R4 fallthrough slot", 64'(out_npc[i*32 +: 32]), 64'(e_npc[i]));
            check(out_seq[i*32 +: 32] == seq_exp + 32'(i), "R6 seq", 64'(out_seq[i*32 +: 32]), 64'(seq_exp + 32'(i)));
        end
        seq_exp = seq_exp + 32'(cnt);
        npc_exp = e_npc[cnt-1];
        if (last_t) tk_exp = tk_exp + 16'd1;
        check(next_pc == npc_exp, "R7 next_pc", 64'(next_pc), 64'(npc_exp));
        check(next_pc_inc == npc_exp + 32'd4, "R7 next_pc_inc", 64'(next_pc_inc), 64'(npc_exp + 32'd4));
        check(taken_total == tk_exp, "R9 taken_total", 64'(taken_total), 64'(tk_exp));
    endtask

    // Faulting request: nothing emitted, state held.
    task automatic run_fault(input int g);
        fetch_pc = 32'h0009_0000 + 32'(g * 4);
        is_ctrl = '1;
        bp_taken = '1;
        req_valid = 1'b1;
        line_fault = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R8 no group on fault", 64'(out_valid), 64'd0);
        check(next_pc == npc_exp, "R8 next_pc held", 64'(next_pc), 64'(npc_exp));
        check(next_pc_inc == npc_exp + 32'd4, "R8 next_pc_inc held", 64'(next_pc_inc), 64'(npc_exp + 32'd4));
        check(taken_total == tk_exp, "R8 taken_total held", 64'(taken_total), 64'(tk_exp));
        line_fault = 1'b0;
    endtask

    initial begin
        #2_000_000;
        bad++; total++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int g;
        g = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R11 reset out_valid", 64'(out_valid), 64'd0);
        check(out_count == 3'd0, "R11 reset out_count", 64'(out_count), 64'd0);
        check(next_pc == 32'd0, "R11 reset next_pc", 64'(next_pc), 64'd0);
        check(next_pc_inc == 32'd4, "R11 reset next_pc_inc", 64'(next_pc_inc), 64'd4);
        check(taken_total == 16'd0, "R11 reset taken_total", 64'(taken_total), 64'd0);
        for (int off = 0; off < 16; off++) begin
            for (int cm = 0; cm < 16; cm++) begin
                for (int tm = 0; tm < 16; tm++) begin
                    run_group(off, cm, tm, g);
                    g++;
                    if ((g % 97) == 0) run_fault(g);
                end
            end
        end
        // Idle cycle: no request means no strobe.
        req_valid = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R10 idle", 64'(out_valid), 64'd0);
        check(next_pc == npc_exp, "R10 idle next_pc", 64'(next_pc), 64'(npc_exp));
        // Fault, then a group: sequence numbering continues unchanged (R8).
        run_fault(1);
        run_group(3, 0, 0, 7);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule